// File: doc/BRIEF.md
# Descriptor-Driven DMA Channel Engine

This block is one DMA channel. Software puts an 8-byte descriptor somewhere in memory and pulses `arm` with the descriptor's address. The channel fetches the descriptor over its byte-wide memory port, decodes it, and then waits for a trigger. Each transfer reads one item (a byte or a 16-bit word) from the source address and writes it to the destination address. After each item, both addresses move by a step that the descriptor selects.

The item count can be fixed in the descriptor. It can also be taken from the first item moved, plus an offset, with the descriptor length acting as a ceiling. Four trigger modes are supported: one item per trigger, a whole block per trigger, and repeating forms of each. The repeating forms re-fetch the descriptor when a pass completes and stay armed. At the end of a pass the channel pulses `done`, and it also pulses `irq` when the descriptor enables the interrupt.

Top module: `dma_chan_engine`

## Requirements
- R1: After `arm` in the idle state, the channel reads the 8 descriptor bytes from `cfg_addr`, `cfg_addr+1`, ... `cfg_addr+7`, in that order. Source address = {byte0, byte1}. Destination address = {byte2, byte3}. Length mode = byte4[7:5]. Length = {byte4[4:0], byte5}. Item size = byte6[7]. Trigger mode = byte6[6:5]. Trigger select = byte6[4:0]. Source step = byte7[7:6]. Destination step = byte7[5:4]. Interrupt enable = byte7[3].
- R2: Length mode 000 or 111 moves exactly `length` items per pass.
- R3: In length modes 001, 010, 011 and 100, the first item read gives a value n. The item count for the pass is n+1, n, n+2 or n+3 respectively. That count includes the first item itself and is capped at `length`. In word mode, n is bits 12:0 of the first word, whose high byte supplies bits 12:8.
- R4: Any of the following ends the pass with a `done` pulse, writes nothing, and disarms the channel: length code 101 or 110, a `length` of 0, or a variable count of 0.
- R5: Item size 0 moves bytes. Item size 1 moves 16-bit words, each as two byte accesses: the high byte at the address, then the low byte at the address+1. This applies to both the read and the write.
- R6: After each item, each address moves by the step code scaled by the item size in bytes: 00 → 0, 01 → +1, 10 → +2, 11 → −1.
- R7: Trigger mode 00 moves one item per trigger. Mode 01 moves the whole pass on one trigger. No item moves before a trigger.
- R8: Trigger modes 10 and 11 behave as 00 and 01 within a pass. After the pass they re-read the descriptor from the same address and stay armed.
- R9: `sw_req` always triggers. Select 1 uses `prev_done`. A select k in 2..30 uses `hw_trig[k-2]`. Other inputs are ignored. One trigger that arrives while the channel is armed is held until the channel uses it.
- R10: After reset, `armed`, `done`, `irq` and `mem_req` are low. `done` is a one-cycle pulse at the end of each pass. A non-repeating pass drops `armed` in the next cycle. `irq` pulses with `done` when interrupt enable is 1.
- R11: While `mem_req` is high and `mem_ready` is low, the address, write-enable and write data stay unchanged. An access completes in a cycle where both are high. Read data is sampled in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| arm | input | 1 | Start: fetch descriptor at `cfg_addr` (idle only) |
| cfg_addr | input | 16 | Descriptor byte address |
| sw_req | input | 1 | Software trigger |
| prev_done | input | 1 | Completion of the preceding channel |
| hw_trig | input | NUM_HW_TRIG | Selectable hardware triggers |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 16 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid when `mem_req & mem_ready` |
| mem_ready | input | 1 | Access completes this cycle |
| armed | output | 1 | Channel holds a descriptor and responds to triggers |
| done | output | 1 | One-cycle end-of-pass pulse |
| irq | output | 1 | End-of-pass interrupt pulse |

## Verification
The hardest case to reach from the ports is the variable-count path. Here the count is only known once the length item arrives. It must then be capped by the descriptor length, or must end the pass at zero without any write. All of this happens while `mem_ready` stalls the very access that delivers that item.

The stimulus plants the length item in memory before arming the channel. It uses directed values that exceed the ceiling, evaluate to zero, or carry stray bits above bit 12 in word mode. It then adds random descriptors across every legal length code, item size and step pair, all under a randomly stalling memory.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    localparam int ADDR_W     = 16;
    localparam int LEN_W      = 13;
    localparam int DESC_BYTES = 8;
    localparam int BIDX_W     = $clog2(DESC_BYTES);
    localparam int TRIG_W     = 5;
    localparam int TRIG_PREV  = 1;
    localparam int TRIG_HW_BASE = 2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DESC,
        ST_WAIT,
        ST_RD,
        ST_WR,
        ST_DONE
    } chan_st_e;

    typedef enum logic [1:0] {
        TM_ONE    = 2'b00,
        TM_BURST  = 2'b01,
        TM_ONE_R  = 2'b10,
        TM_BURST_R = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        STP_ZERO = 2'b00,
        STP_ONE  = 2'b01,
        STP_TWO  = 2'b10,
        STP_BACK = 2'b11
    } step_e;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [2:0]        lmode;
        logic [LEN_W-1:0]  len;
        logic              wide;
        tmode_e            tmode;
        logic [TRIG_W-1:0] trig;
        step_e             sstep;
        step_e             dstep;
        logic              irq_en;
    } desc_t;

    // Bits 63..56 hold the first descriptor byte; bits 2..0 are unused.
    function automatic desc_t unpack_desc(input logic [63:3] r);
        desc_t d;
        d.src    = r[63:48];
        d.dst    = r[47:32];
        d.lmode  = r[31:29];
        d.len    = r[28:16];
        d.wide   = r[15];
        d.tmode  = tmode_e'(r[14:13]);
        d.trig   = r[12:8];
        d.sstep  = step_e'(r[7:6]);
        d.dstep  = step_e'(r[5:4]);
        d.irq_en = r[3];
        return d;
    endfunction

    function automatic logic lmode_fixed(input logic [2:0] m);
        return (m == 3'b000) || (m == 3'b111);
    endfunction

    function automatic logic lmode_reserved(input logic [2:0] m);
        return (m == 3'b101) || (m == 3'b110);
    endfunction

    function automatic logic [1:0] lmode_extra(input logic [2:0] m);
        case (m)
            3'b001:  return 2'd1;
            3'b011:  return 2'd2;
            3'b100:  return 2'd3;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic is_burst(input tmode_e t);
        return (t == TM_BURST) || (t == TM_BURST_R);
    endfunction

    function automatic logic is_repeat(input tmode_e t);
        return (t == TM_ONE_R) || (t == TM_BURST_R);
    endfunction

    function automatic logic [ADDR_W-1:0] step_delta(input step_e s, input logic wide);
        logic [ADDR_W-1:0] unit;
        unit = wide ? ADDR_W'(2) : ADDR_W'(1);
        case (s)
            STP_ZERO: return '0;
            STP_ONE:  return unit;
            STP_TWO:  return unit << 1;
            default:  return ADDR_W'(0) - unit;
        endcase
    endfunction

endpackage

// File: rtl/dma_len_calc.sv
module dma_len_calc
    import dma_chan_pkg::*;
(
    input  logic [2:0]        lmode,
    input  logic [LEN_W-1:0]  len_max,
    input  logic              wide,
    input  logic [LEN_W-9:0]  hi_bits,
    input  logic [7:0]        lo_byte,
    output logic [LEN_W-1:0]  total
);

    logic [LEN_W-1:0] n_val;
    logic [LEN_W:0]   sum;

    always_comb begin
        n_val = wide ? {hi_bits, lo_byte} : {{(LEN_W-8){1'b0}}, lo_byte};
        sum   = {1'b0, n_val} + (LEN_W+1)'(lmode_extra(lmode));
        if (lmode_fixed(lmode)) begin
            total = len_max;
        end else if (sum > {1'b0, len_max}) begin
            total = len_max;
        end else begin
            total = sum[LEN_W-1:0];
        end
    end

endmodule

// File: rtl/dma_trig_sel.sv
module dma_trig_sel
    import dma_chan_pkg::*;
#(
    parameter int NUM_HW_TRIG = 29
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   armed,
    input  logic [TRIG_W-1:0]      sel,
    input  logic                   sw_req,
    input  logic                   prev_done,
    input  logic [NUM_HW_TRIG-1:0] hw_trig,
    input  logic                   consume,
    output logic                   pending
);

    logic hit_hw;
    logic hit;

    always_comb begin
        hit_hw = 1'b0;
        for (int k = 0; k < NUM_HW_TRIG; k++) begin
            if (sel == TRIG_W'(k + TRIG_HW_BASE)) begin
                hit_hw = hw_trig[k];
            end
        end
        hit = sw_req | ((sel == TRIG_W'(TRIG_PREV)) & prev_done) | hit_hw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
        end else if (!armed) begin
            pending <= 1'b0;
        end else begin
            pending <= (pending & ~consume) | hit;
        end
    end

    // R9
    pend_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !pending);

endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] src_init,
    input  logic [ADDR_W-1:0] dst_init,
    input  logic              adv,
    input  logic [ADDR_W-1:0] delta_s,
    input  logic [ADDR_W-1:0] delta_d,
    output logic [ADDR_W-1:0] src,
    output logic [ADDR_W-1:0] dst
);

    always_ff @(posedge clk) begin
        if (rst) begin
            src <= '0;
            dst <= '0;
        end else if (load) begin
            src <= src_init;
            dst <= dst_init;
        end else if (adv) begin
            src <= src + delta_s;
            dst <= dst + delta_d;
        end
    end

    // R6
    src_zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && delta_s == '0) |=> $stable(src));

    // R6
    dst_zero_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv && !load && delta_d == '0) |=> $stable(dst));

endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
    import dma_chan_pkg::*;
#(
    parameter int NUM_HW_TRIG = 29
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   arm,
    input  logic [ADDR_W-1:0]      cfg_addr,
    input  logic                   sw_req,
    input  logic                   prev_done,
    input  logic [NUM_HW_TRIG-1:0] hw_trig,
    output logic                   mem_req,
    output logic                   mem_we,
    output logic [ADDR_W-1:0]      mem_addr,
    output logic [7:0]             mem_wdata,
    input  logic [7:0]             mem_rdata,
    input  logic                   mem_ready,
    output logic                   armed,
    output logic                   done,
    output logic                   irq
);

    localparam int RAW_W = (DESC_BYTES - 1) * 8;

    chan_st_e          st;
    logic [BIDX_W-1:0] bidx;
    logic [RAW_W-1:0]  raw;
    desc_t             desc;
    desc_t             desc_next;
    logic [ADDR_W-1:0] base_q;
    logic [7:0]        hi_q;
    logic [7:0]        lo_q;
    logic              phase;
    logic              first;
    logic              fault;
    logic [LEN_W-1:0]  remain;

    logic              hs;
    logic              last_byte;
    logic              pend;
    logic              consume;
    logic              desc_last;
    logic              item_adv;
    logic [LEN_W-1:0]  var_total;
    logic [ADDR_W-1:0] src_cur;
    logic [ADDR_W-1:0] dst_cur;
    logic [ADDR_W-1:0] byte_off;

    // ---------------- handshake and decode ----------------
    always_comb begin
        mem_req   = (st == ST_DESC) || (st == ST_RD) || (st == ST_WR);
        mem_we    = (st == ST_WR);
        hs        = mem_req && mem_ready;
        last_byte = !desc.wide || phase;
        byte_off  = ADDR_W'(desc.wide & phase);
        desc_last = (st == ST_DESC) && hs && (bidx == BIDX_W'(DESC_BYTES - 1));
        desc_next = unpack_desc({raw, mem_rdata[7:3]});
        item_adv  = (st == ST_WR) && hs && last_byte;
        consume   = (st == ST_WAIT) && pend;
        armed     = (st != ST_IDLE);
        done      = (st == ST_DONE);
        irq       = done && desc.irq_en;
    end

    always_comb begin
        case (st)
            ST_DESC: mem_addr = base_q + ADDR_W'(bidx);
            ST_RD:   mem_addr = src_cur + byte_off;
            ST_WR:   mem_addr = dst_cur + byte_off;
            default: mem_addr = '0;
        endcase
        mem_wdata = (desc.wide && !phase) ? hi_q : lo_q;
    end

    // ---------------- sub-blocks ----------------
    dma_trig_sel #(
        .NUM_HW_TRIG (NUM_HW_TRIG)
    ) u_trig (
        .clk       (clk),
        .rst       (rst),
        .armed     (armed),
        .sel       (desc.trig),
        .sw_req    (sw_req),
        .prev_done (prev_done),
        .hw_trig   (hw_trig),
        .consume   (consume),
        .pending   (pend)
    );

    dma_len_calc u_len (
        .lmode   (desc.lmode),
        .len_max (desc.len),
        .wide    (desc.wide),
        .hi_bits (hi_q[LEN_W-9:0]),
        .lo_byte (mem_rdata),
        .total   (var_total)
    );

    dma_addr_gen u_addr (
        .clk      (clk),
        .rst      (rst),
        .load     (desc_last),
        .src_init (desc_next.src),
        .dst_init (desc_next.dst),
        .adv      (item_adv),
        .delta_s  (step_delta(desc.sstep, desc.wide)),
        .delta_d  (step_delta(desc.dstep, desc.wide)),
        .src      (src_cur),
        .dst      (dst_cur)
    );

    // ---------------- channel sequencer ----------------
    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= ST_IDLE;
            bidx   <= '0;
            raw    <= '0;
            desc   <= '0;
            base_q <= '0;
            hi_q   <= '0;
            lo_q   <= '0;
            phase  <= 1'b0;
            first  <= 1'b0;
            fault  <= 1'b0;
            remain <= '0;
        end else begin
            case (st)
                ST_IDLE: begin
                    if (arm) begin
                        base_q <= cfg_addr;
                        bidx   <= '0;
                        st     <= ST_DESC;
                    end
                end
                ST_DESC: begin
                    if (hs) begin
                        raw  <= {raw[RAW_W-9:0], mem_rdata};
                        bidx <= bidx + 1'b1;
                        if (desc_last) begin
                            desc   <= desc_next;
                            remain <= desc_next.len;
                            first  <= 1'b1;
                            phase  <= 1'b0;
                            if (lmode_reserved(desc_next.lmode) || desc_next.len == '0) begin
                                fault <= 1'b1;
                                st    <= ST_DONE;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_WAIT: begin
                    if (pend) begin
                        phase <= 1'b0;
                        st    <= ST_RD;
                    end
                end
                ST_RD: begin
                    if (hs) begin
                        if (!last_byte) begin
                            hi_q  <= mem_rdata;
                            phase <= 1'b1;
                        end else begin
                            lo_q  <= mem_rdata;
                            phase <= 1'b0;
                            first <= 1'b0;
                            if (first && !lmode_fixed(desc.lmode)) begin
                                if (var_total == '0) begin
                                    fault <= 1'b1;
                                    st    <= ST_DONE;
                                end else begin
                                    remain <= var_total;
                                    st     <= ST_WR;
                                end
                            end else begin
                                st <= ST_WR;
                            end
                        end
                    end
                end
                ST_WR: begin
                    if (hs) begin
                        if (!last_byte) begin
                            phase <= 1'b1;
                        end else begin
                            phase  <= 1'b0;
                            remain <= remain - 1'b1;
                            if (remain == LEN_W'(1)) begin
                                st <= ST_DONE;
                            end else if (is_burst(desc.tmode)) begin
                                st <= ST_RD;
                            end else begin
                                st <= ST_WAIT;
                            end
                        end
                    end
                end
                ST_DONE: begin
                    fault <= 1'b0;
                    if (is_repeat(desc.tmode) && !fault) begin
                        bidx <= '0;
                        st   <= ST_DESC;
                    end else begin
                        st <= ST_IDLE;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R10
    disarm_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        (done && !is_repeat(desc.tmode)) |=> !armed);

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                     && $stable(mem_wdata)));

    // R3
    count_ceiling_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_WR) |-> (remain != '0 && remain <= desc.len));

    // R7
    no_move_unarmed_chk: assert property (@(posedge clk) disable iff (rst)
        !armed |-> !mem_req);

endmodule

// File: tb/sim_dma_chan_engine.sv
module sim_dma_chan_engine;

    localparam int CLK_PERIOD = 10;
    localparam int NHW = 29;
    localparam int DESC_AT = 'h100;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           arm = 1'b0;
    logic [15:0]    cfg_addr = 16'(DESC_AT);
    logic           sw_req = 1'b0;
    logic           prev_done = 1'b0;
    logic [NHW-1:0] hw_trig = '0;
    logic           mem_req, mem_we, mem_ready;
    logic [15:0]    mem_addr;
    logic [7:0]     mem_wdata, mem_rdata;
    logic           armed, done, irq;

    logic [7:0] mem [0:4095];
    assign mem_rdata = mem[mem_addr[11:0]];

    int checks = 0;
    int errors = 0;

    int wcnt, rcnt, dcnt, icnt, hold_err;
    int wlog_a [0:255];
    int wlog_d [0:255];
    int rlog_a [0:255];
    logic clr_log = 1'b0;
    logic prev_stall;
    int   prev_a, prev_we, prev_wd;

    int ea [0:255];
    int ed [0:255];
    int ecnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_chan_engine #(.NUM_HW_TRIG(NHW)) u0 (
        .clk(clk), .rst(rst), .arm(arm), .cfg_addr(cfg_addr),
        .sw_req(sw_req), .prev_done(prev_done), .hw_trig(hw_trig),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .armed(armed), .done(done), .irq(irq)
    );

    initial mem_ready = 1'b1;
    always @(negedge clk) mem_ready <= ($urandom % 4) != 0;

    always @(posedge clk) begin
        if (clr_log) begin
            wcnt = 0; rcnt = 0; dcnt = 0; icnt = 0; hold_err = 0; prev_stall = 1'b0;
        end else begin
            if (prev_stall && (!mem_req || int'(mem_addr) != prev_a ||
                               int'(mem_we) != prev_we || int'(mem_wdata) != prev_wd))
                hold_err++;
            prev_stall = mem_req && !mem_ready;
            prev_a = int'(mem_addr); prev_we = int'(mem_we); prev_wd = int'(mem_wdata);
            if (mem_req && mem_ready && mem_we && wcnt < 256) begin
                wlog_a[wcnt] = int'(mem_addr); wlog_d[wcnt] = int'(mem_wdata); wcnt++;
            end
            if (mem_req && mem_ready && !mem_we && rcnt < 256) begin
                rlog_a[rcnt] = int'(mem_addr); rcnt++;
            end
            if (done) dcnt++;
            if (irq) icnt++;
        end
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0;
    endtask

    task automatic put_desc(input int src, input int dst, input int lmode, input int len,
                            input int wide, input int tm, input int trig,
                            input int ss, input int ds, input int ien);
        mem[DESC_AT+0] = 8'(src >> 8);
        mem[DESC_AT+1] = 8'(src);
        mem[DESC_AT+2] = 8'(dst >> 8);
        mem[DESC_AT+3] = 8'(dst);
        mem[DESC_AT+4] = 8'(((lmode & 7) << 5) | ((len >> 8) & 'h1F));
        mem[DESC_AT+5] = 8'(len);
        mem[DESC_AT+6] = 8'(((wide & 1) << 7) | ((tm & 3) << 5) | (trig & 'h1F));
        mem[DESC_AT+7] = 8'(((ss & 3) << 6) | ((ds & 3) << 4) | ((ien & 1) << 3));
    endtask

    function automatic int step_of(input int code, input int wide);
        int u = wide ? 2 : 1;
        case (code & 3)
            0: return 0;
            1: return u;
            2: return 2 * u;
            default: return -u;
        endcase
    endfunction

    task automatic model(input int src, input int dst, input int lmode, input int len,
                         input int wide, input int ss, input int ds);
        int tot, n, off, s, d;
        if (lmode == 5 || lmode == 6 || len == 0) tot = 0;
        else if (lmode == 0 || lmode == 7) tot = len;
        else begin
            n = wide ? (((int'(mem[src & 'hFFF]) << 8) | int'(mem[(src + 1) & 'hFFF])) & 'h1FFF)
                     : int'(mem[src & 'hFFF]);
            off = (lmode == 1) ? 1 : (lmode == 2) ? 0 : (lmode == 3) ? 2 : 3;
            tot = (n + off > len) ? len : n + off;
        end
        ecnt = 0; s = src; d = dst;
        for (int i = 0; i < tot; i++) begin
            ea[ecnt] = d & 'hFFFF; ed[ecnt] = int'(mem[s & 'hFFF]); ecnt++;
            if (wide) begin
                ea[ecnt] = (d + 1) & 'hFFFF; ed[ecnt] = int'(mem[(s + 1) & 'hFFF]); ecnt++;
            end
            s = (s + step_of(ss, wide)) & 'hFFFF;
            d = (d + step_of(ds, wide)) & 'hFFFF;
        end
    endtask

    task automatic cmp_log(input string tag);
        check({tag, " write count"}, wcnt, ecnt);
        for (int i = 0; i < ecnt && i < wcnt; i++) begin
            check({tag, " write addr"}, wlog_a[i], ea[i]);
            check({tag, " write data"}, wlog_d[i], ed[i]);
        end
    endtask

    task automatic pulse_arm();
        arm = 1'b1; @(negedge clk); arm = 1'b0;
    endtask

    task automatic pulse_sw();
        sw_req = 1'b1; @(negedge clk); sw_req = 1'b0;
    endtask

    task automatic wait_done(input int maxc);
        for (int i = 0; i < maxc && dcnt == 0; i++) @(negedge clk);
    endtask

    task automatic run_case(input string tag, input int src, input int dst, input int lmode,
                            input int len, input int wide, input int tm,
                            input int ss, input int ds, input int ien);
        do_reset();
        put_desc(src, dst, lmode, len, wide, tm, 0, ss, ds, ien);
        model(src, dst, lmode, len, wide, ss, ds);
        pulse_arm();
        for (int it = 0; it < 80 && dcnt == 0; it++) begin
            pulse_sw();
            repeat (14) @(negedge clk);
        end
        repeat (3) @(negedge clk);
        cmp_log(tag);
        check({tag, " R10 done count"}, dcnt, 1);
        check({tag, " R10 irq count"}, icnt, ien);
        check({tag, " R10 disarmed"}, int'(armed), 0);
        check({tag, " R11 hold"}, hold_err, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd7103);
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        do_reset();
        @(negedge clk);
        // R10 reset state
        check("R10 reset armed", int'(armed), 0);
        check("R10 reset done", int'(done), 0);
        check("R10 reset irq", int'(irq), 0);
        check("R10 reset mem_req", int'(mem_req), 0);

        // R1 descriptor order and R2 fixed count
        run_case("R1 R2 fixed", 'h200, 'h900, 0, 3, 0, 1, 1, 1, 1);
        for (int k = 0; k < 8; k++) check("R1 desc read addr", rlog_a[k], DESC_AT + k);
        run_case("R2 code7", 'h220, 'h910, 7, 5, 0, 1, 2, 1, 0);

        // R3 variable modes
        mem['h300] = 8'd50;
        run_case("R3 cap", 'h300, 'h920, 1, 4, 0, 1, 1, 1, 0);
        check("R3 capped count", wcnt, 4);
        mem['h310] = 8'd2;
        run_case("R3 plus2", 'h310, 'h930, 3, 10, 0, 1, 1, 1, 0);
        check("R3 plus2 count", wcnt, 4);
        mem['h320] = 8'd2;
        run_case("R3 plus3", 'h320, 'h940, 4, 10, 0, 1, 1, 1, 1);
        check("R3 plus3 count", wcnt, 5);
        mem['h330] = 8'hE0; mem['h331] = 8'd3;
        run_case("R3 R5 word len", 'h330, 'h950, 2, 9, 1, 1, 1, 1, 0);
        check("R3 word count bytes", wcnt, 6);
        check("R5 hi first addr", wlog_a[0], 'h950);
        check("R5 hi first data", wlog_d[0], 'hE0);
        check("R5 lo second addr", wlog_a[1], 'h951);

        // R4 zero and reserved
        run_case("R4 code5", 'h340, 'h960, 5, 4, 0, 1, 1, 1, 1);
        run_case("R4 code6", 'h340, 'h960, 6, 4, 1, 0, 1, 1, 0);
        run_case("R4 len0", 'h340, 'h960, 0, 0, 0, 1, 1, 1, 0);
        mem['h350] = 8'd0;
        run_case("R4 var zero", 'h350, 'h960, 2, 6, 0, 1, 1, 1, 1);
        check("R4 no write", wcnt, 0);

        // R6 steps
        run_case("R6 back word", 'h360, 'h980, 0, 4, 1, 1, 3, 2, 0);
        run_case("R6 hold dst", 'h370, 'h990, 0, 3, 0, 1, 2, 0, 0);
        run_case("R6 back byte", 'h380, 'h9A0, 0, 4, 0, 1, 1, 3, 0);

        // R7 one item per trigger
        do_reset();
        put_desc('h3A0, 'h9C0, 0, 3, 0, 0, 0, 1, 1, 0);
        model('h3A0, 'h9C0, 0, 3, 0, 1, 1);
        pulse_arm();
        repeat (30) @(negedge clk);
        check("R7 nothing before trigger", wcnt, 0);
        for (int i = 1; i <= 3; i++) begin
            pulse_sw();
            repeat (30) @(negedge clk);
            check("R7 one item per trigger", wcnt, i);
        end
        check("R7 done after last", dcnt, 1);
        cmp_log("R7 single");

        // R9 trigger selection
        do_reset();
        put_desc('h3B0, 'h9D0, 0, 2, 0, 0, 7, 1, 1, 0);
        pulse_arm();
        repeat (30) @(negedge clk);
        hw_trig[6] = 1'b1; @(negedge clk); hw_trig[6] = 1'b0;
        prev_done = 1'b1; @(negedge clk); prev_done = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 other inputs ignored", wcnt, 0);
        hw_trig[5] = 1'b1; @(negedge clk); hw_trig[5] = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 selected hw input", wcnt, 1);
        do_reset();
        put_desc('h3B0, 'h9D0, 0, 2, 0, 0, 1, 1, 1, 0);
        pulse_arm();
        repeat (30) @(negedge clk);
        hw_trig = '1; @(negedge clk); hw_trig = '0;
        repeat (30) @(negedge clk);
        check("R9 hw ignored under prev select", wcnt, 0);
        prev_done = 1'b1; @(negedge clk); prev_done = 1'b0;
        repeat (30) @(negedge clk);
        check("R9 prev_done trigger", wcnt, 1);

        // R8 repeated block
        do_reset();
        put_desc('h3C0, 'h9E0, 0, 2, 0, 3, 0, 1, 1, 1);
        pulse_arm();
        repeat (30) @(negedge clk);
        pulse_sw();
        wait_done(200);
        repeat (40) @(negedge clk);
        check("R8 stays armed", int'(armed), 1);
        check("R8 descriptor reloaded", rcnt, 18);
        check("R8 reload read addr", rlog_a[10], DESC_AT);
        pulse_sw();
        repeat (60) @(negedge clk);
        check("R8 second pass writes", wcnt, 4);
        check("R8 second done", dcnt, 2);
        check("R8 armed after second", int'(armed), 1);

        // random descriptors: R2 R3 R5 R6 R7
        for (int t = 0; t < 40; t++) begin
            int src, lm, wd, sel;
            src = 'h2C0 + ($urandom % 128);
            sel = $urandom % 6;
            lm = (sel == 5) ? 7 : sel;
            wd = $urandom % 2;
            if (wd) begin
                mem[src] = 8'($urandom & 'hE0);
                mem[src + 1] = 8'($urandom % 16);
            end else begin
                mem[src] = 8'($urandom % 16);
            end
            run_case("R2 R3 R5 R6 R7 random", src, 'h900 + ($urandom % 64), lm,
                     1 + ($urandom % 12), wd, $urandom % 2,
                     $urandom % 4, $urandom % 4, $urandom % 2);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule